// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block gathers sixteen device interrupt lines into one request to a processor. It does this with two identical eight-input controllers. The secondary controller takes system lines 8 to 15. Its combined request takes the place of input 2 on the primary, which takes system lines 0 to 7. Input 2 of the primary is therefore the cascade, and fifteen lines remain usable.

Each controller latches rising edges, keeps an in-service register and applies a per-line mask. It picks the lowest-numbered eligible input. When the processor acknowledges, the controller moves the winning bit into service and forms a vector from an 8-aligned base plus the input index. If the cascade input wins, the vector comes from the secondary instead.

Software reaches both controllers over a byte-wide port bus. Each controller has a command address, which takes end-of-interrupt and base-load writes and reads back the in-service register. Each also has a data address, which reads and writes the mask. A handler for a secondary line must finish at both controllers.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset, cpu_irq is low, both in-service registers read 00h and both mask registers read 00h.
- R2: A rising edge on a primary line n (n not 2) raises cpu_irq. An acknowledge then yields vector 08h+n on cpu_vec in the cycle after the acknowledge, and clears the request. A line that only stays high makes no new request.
- R3: Priority is fixed, with lower input index winning. On the primary, all secondary lines rank at input 2: below system lines 0 and 1, above lines 3 to 7.
- R4: While a source's in-service bit is set, that source does not raise cpu_irq. An edge that arrives meanwhile stays latched and is delivered after the end-of-interrupt.
- R5: Writing 20h to a command port (20h primary, A0h secondary) clears only the lowest-numbered set in-service bit of that controller. A read of the command port returns the in-service register, with bit k for input k.
- R6: A secondary line k gives vector 70h+k and sets both secondary bit k and primary bit 2 in service. After an end-of-interrupt to the secondary alone, primary bit 2 stays set. Further secondary requests stay blocked until the primary also gets an end-of-interrupt.
- R7: The data port (21h primary, A1h secondary) reads and writes the mask, with bit k for input k. A masked edge is latched but not forwarded. Clearing the mask bit delivers it.
- R8: A command write with bit 0 set loads that controller's vector base from bits 7:3 of the data. The default bases are 08h for the primary and 70h for the secondary.
- R9: System line 2 (irq_lines bit 2) has no effect.
- R10: An acknowledge with no eligible request returns vector base+7 of the primary and changes no in-service bit.
- R11: A command write with bit 0 clear and a value other than 20h has no effect on the in-service register or the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 16 | System interrupt lines 0..15, rising edge requests |
| reg_addr | input | 8 | Port address of a register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Acknowledge pulse from the processor |
| cpu_vec | output | 8 | Vector of the last acknowledge |

## Verification
The hardest state to reach is one where the secondary has finished but the primary has not. In that state the secondary holds a fresh eligible request while primary input 2 is still in service. The stimulus gets there in steps. It serves one secondary line and then pulses a second secondary line during that service. Next it sends an end-of-interrupt only to the secondary. The bench confirms cpu_irq stays low and reads primary bit 2 as set. Only after the primary's end-of-interrupt does the bench expect the second vector.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned IDX_W = $clog2(LINES);
  localparam int unsigned BASE_W = 8 - IDX_W;
  localparam logic [7:0] EOI_CODE = 8'h20;

  typedef logic [LINES-1:0] lines_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic       we;
    logic       sel_cmd;
    logic [7:0] data;
  } regwr_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter logic [7:0] RST_BASE   = 8'h08,
  parameter lines_t     LEVEL_MASK = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  lines_t     req_in,
  input  regwr_t     wr,
  input  logic       ack,
  output logic       int_o,
  output idx_t       win_idx,
  output logic [7:0] vec_o,
  output lines_t     isr_o,
  output lines_t     mask_o
);
  lines_t prev_q, irr_q, isr_q, mask_q;
  lines_t prev_d, irr_d, isr_d, mask_d;
  logic [BASE_W-1:0] base_q, base_d;
  lines_t pend, elig, win_1h, eoi_1h, edge_v;
  logic   isr_hit, eoi_cmd, mask_en, base_en;
  idx_t   isr_idx;

  assign pend = (irr_q & ~LEVEL_MASK) | (req_in & LEVEL_MASK);
  assign elig = pend & ~isr_q & ~mask_q;

  irq_prio_pick #(.N(LINES)) u_win (.req(elig),  .hit(int_o),   .idx(win_idx));
  irq_prio_pick #(.N(LINES)) u_top (.req(isr_q), .hit(isr_hit), .idx(isr_idx));

  always_comb begin
    eoi_cmd = wr.we && wr.sel_cmd && (wr.data == EOI_CODE);
    mask_en = wr.we && !wr.sel_cmd;
    base_en = wr.we && wr.sel_cmd && wr.data[0];
    edge_v  = req_in & ~prev_q;
    win_1h  = (ack && int_o) ? (lines_t'(1) << win_idx) : '0;
    eoi_1h  = (eoi_cmd && isr_hit) ? (lines_t'(1) << isr_idx) : '0;
    prev_d  = req_in;
    irr_d   = ((irr_q & ~win_1h) | edge_v) & ~LEVEL_MASK;
    isr_d   = (isr_q & ~eoi_1h) | win_1h;
    mask_d  = wr.data;
    base_d  = wr.data[7:IDX_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      base_q <= RST_BASE[7:IDX_W];
    end else begin
      prev_q <= prev_d;
      irr_q  <= irr_d;
      isr_q  <= isr_d;
      if (mask_en) mask_q <= mask_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign vec_o  = {base_q, int_o ? win_idx : idx_t'(LINES - 1)};
  assign isr_o  = isr_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
  import irq_pkg::*;
#(
  parameter logic [7:0]  PRI_PORT = 8'h20,
  parameter logic [7:0]  SEC_PORT = 8'hA0,
  parameter logic [7:0]  PRI_BASE = 8'h08,
  parameter logic [7:0]  SEC_BASE = 8'h70,
  parameter int unsigned CASC_IN  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_lines,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        cpu_irq,
  input  logic        cpu_ack,
  output logic [7:0]  cpu_vec
);
  localparam int unsigned UNITS = 2;
  localparam logic [7:0] PORTS [UNITS] = '{PRI_PORT, SEC_PORT};
  localparam logic [7:0] BASES [UNITS] = '{PRI_BASE, SEC_BASE};

  lines_t     req_v  [UNITS];
  regwr_t     wr_v   [UNITS];
  logic       ack_v  [UNITS];
  logic       int_v  [UNITS];
  idx_t       idx_v  [UNITS];
  logic [7:0] vecn_v [UNITS];
  lines_t     isr_v  [UNITS];
  lines_t     mask_v [UNITS];
  logic       hit_v  [UNITS];
  logic       casc_win;
  logic [7:0] vec_q, vec_d;

  always_comb begin
    req_v[0]          = irq_lines[7:0];
    req_v[0][CASC_IN] = int_v[1];
    req_v[1]          = irq_lines[15:8];
    casc_win          = int_v[0] && (idx_v[0] == idx_t'(CASC_IN));
    ack_v[0]          = cpu_ack;
    ack_v[1]          = cpu_ack && casc_win;
  end

  for (genvar g = 0; g < UNITS; g++) begin : g_unit
    assign hit_v[g]        = (reg_addr[7:1] == PORTS[g][7:1]);
    assign wr_v[g].we      = reg_wr && hit_v[g];
    assign wr_v[g].sel_cmd = !reg_addr[0];
    assign wr_v[g].data    = reg_wdata;

    irq_unit #(
      .RST_BASE  (BASES[g]),
      .LEVEL_MASK((g == 0) ? (lines_t'(1) << CASC_IN) : lines_t'(0))
    ) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_in (req_v[g]),
      .wr     (wr_v[g]),
      .ack    (ack_v[g]),
      .int_o  (int_v[g]),
      .win_idx(idx_v[g]),
      .vec_o  (vecn_v[g]),
      .isr_o  (isr_v[g]),
      .mask_o (mask_v[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (hit_v[u]) reg_rdata = reg_addr[0] ? mask_v[u] : isr_v[u];
    end
    vec_d = casc_win ? vecn_v[1] : vecn_v[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (cpu_ack) vec_q <= vec_d;
  end

  assign cpu_irq = int_v[0];
  assign cpu_vec = vec_q;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter logic [7:0] PRI_PORT = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_ack,
  input logic       cpu_irq,
  input logic       reg_wr,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] prim_isr,
  input logic [7:0] sec_isr,
  input logic [7:0] prim_mask
);
  logic pri_eoi;
  assign pri_eoi = reg_wr && (reg_addr == PRI_PORT) && (reg_wdata == 8'h20);

  // R2: an acknowledge of a live request puts exactly one more primary bit in service
  a_r2_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && cpu_irq && !reg_wr |=>
      $countones(prim_isr) == $countones($past(prim_isr)) + 1);

  // R5: a primary end-of-interrupt removes at most one bit
  a_r5_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    pri_eoi && !cpu_ack |=>
      ($countones(prim_isr) + (($past(prim_isr) != 8'h00) ? 1 : 0))
        == $countones($past(prim_isr)));

  // R6: a new secondary in-service bit always comes with primary cascade in service
  a_r6_casc_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sec_isr) > $countones($past(sec_isr))) |-> prim_isr[2]);

  // R7: with every primary input masked, no request reaches the processor
  a_r7_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (prim_mask == 8'hFF) |-> !cpu_irq);

  // R10: a spurious acknowledge leaves both in-service registers alone
  a_r10_spurious_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && !cpu_irq && !reg_wr |=> $stable(prim_isr) && $stable(sec_isr));
endmodule

bind irq_cascade_top irq_cascade_chk #(.PRI_PORT(PRI_PORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_ack  (cpu_ack),
  .cpu_irq  (cpu_irq),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .prim_isr (isr_v[0]),
  .sec_isr  (isr_v[1]),
  .prim_mask(mask_v[0])
);

// File: tb/sim_irq_cascade_top.sv
`timescale 1ns/1ps
module sim_irq_cascade_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        cpu_irq;
  logic        cpu_ack = 1'b0;
  logic [7:0]  cpu_vec;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_cascade_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .cpu_vec(cpu_vec)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #0.1 v = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] m);
    irq_lines = irq_lines | m;
    @(negedge clk);
    irq_lines = irq_lines & ~m;
  endtask

  task automatic ack(output int v);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
    v = cpu_vec;
  endtask

  task automatic t_reset();
    int v;
    check("R1 irq", cpu_irq, 0);
    rd(8'h20, v); check("R1 pri isr", v, 0);
    rd(8'h21, v); check("R1 pri mask", v, 0);
    rd(8'hA0, v); check("R1 sec isr", v, 0);
    rd(8'hA1, v); check("R1 sec mask", v, 0);
  endtask

  task automatic t_basic();
    int v;
    irq_lines[5] = 1'b1;
    @(negedge clk);
    check("R2 irq raised", cpu_irq, 1);
    ack(v); check("R2 vector line5", v, 8'h0D);
    check("R2 irq cleared", cpu_irq, 0);
    rd(8'h20, v); check("R2 isr bit5", v, 8'h20);
    wr(8'h20, 8'h20);
    repeat (2) @(negedge clk);
    check("R2 held level no rerequest", cpu_irq, 0);
    irq_lines[5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    int v;
    pulse(16'h0248);
    ack(v); check("R3 secondary ranks at input 2", v, 8'h71);
    ack(v); check("R3 line3 next", v, 8'h0B);
    ack(v); check("R3 line6 last", v, 8'h0E);
    rd(8'h20, v); check("R3 pri isr", v, 8'h4C);
    wr(8'h20, 8'h20);
    rd(8'h20, v); check("R5 eoi clears lowest only", v, 8'h48);
    wr(8'hA0, 8'h20);
    rd(8'hA0, v); check("R5 sec eoi", v, 0);
    wr(8'h20, 8'h20); wr(8'h20, 8'h20);
    rd(8'h20, v); check("R5 pri clear", v, 0);
  endtask

  task automatic t_block();
    int v;
    pulse(16'h0010);
    ack(v); check("R4 vector line4", v, 8'h0C);
    pulse(16'h0010);
    check("R4 blocked while in service", cpu_irq, 0);
    wr(8'h20, 8'h20);
    check("R4 delivered after eoi", cpu_irq, 1);
    ack(v); check("R4 second vector", v, 8'h0C);
    wr(8'h20, 8'h20);
  endtask

  task automatic t_casc();
    int v;
    pulse(16'h1000);
    ack(v); check("R6 vector line12", v, 8'h74);
    pulse(16'h0400);
    check("R6 blocked by cascade", cpu_irq, 0);
    wr(8'hA0, 8'h20);
    check("R6 still blocked after sec eoi", cpu_irq, 0);
    rd(8'h20, v); check("R6 pri bit2 held", v, 8'h04);
    wr(8'h20, 8'h20);
    check("R6 released by pri eoi", cpu_irq, 1);
    ack(v); check("R6 vector line10", v, 8'h72);
    wr(8'hA0, 8'h20); wr(8'h20, 8'h20);
  endtask

  task automatic t_mask();
    int v;
    wr(8'h21, 8'h02);
    rd(8'h21, v); check("R7 mask readback", v, 8'h02);
    pulse(16'h0002);
    @(negedge clk);
    check("R7 masked not forwarded", cpu_irq, 0);
    wr(8'h21, 8'h00);
    check("R7 unmask delivers", cpu_irq, 1);
    ack(v); check("R7 vector line1", v, 8'h09);
    wr(8'h20, 8'h20);
  endtask

  task automatic t_base();
    int v;
    wr(8'hA0, 8'h91);
    pulse(16'h8000);
    ack(v); check("R8 new secondary base", v, 8'h97);
    wr(8'hA0, 8'h20); wr(8'h20, 8'h20);
    wr(8'hA0, 8'h71);
  endtask

  task automatic t_line2();
    int v;
    pulse(16'h0004);
    @(negedge clk);
    check("R9 line2 no irq", cpu_irq, 0);
    rd(8'h20, v); check("R9 line2 no state", v, 0);
  endtask

  task automatic t_spur();
    int v;
    ack(v); check("R10 spurious vector", v, 8'h0F);
    rd(8'h20, v); check("R10 isr unchanged", v, 0);
  endtask

  task automatic t_badcmd();
    int v;
    pulse(16'h0001);
    ack(v);
    wr(8'h20, 8'h40);
    rd(8'h20, v); check("R11 isr kept", v, 8'h01);
    wr(8'h20, 8'h20);
    pulse(16'h0008);
    ack(v); check("R11 base kept", v, 8'h0B);
    wr(8'h20, 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prio();
    t_block();
    t_casc();
    t_mask();
    t_base();
    t_line2();
    t_spur();
    t_badcmd();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule